// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

This block computes the Montgomery product P = X·Y·2^(−m) mod M. The operands X, Y and the odd modulus M are m bits wide, and X, Y < M. A single word-wide adder does the work one word per clock. It scans X one bit at a time, starting at the least significant bit. For each bit it makes one pass over the words of Y, M and the running partial sum S, and all three live in word-addressed on-chip RAMs.

The halving of S that each bit step needs is not a separate pass. Each word of S is written back one cycle after it was computed, and the write carries the low bit of the next-higher word into its top bit. After all m bits, a borrow-chained compare pass checks S against M. A subtract pass then brings S into the range [0, M) when needed.

The host writes the operands through one word-wide write port and pulses `start`. It waits for the one-cycle `done` pulse and then reads the product back one word at a time.

Top module: `mont_mul_serial`

## Requirements
- R1: After a run with an odd M and X, Y < M, the words of S read back form exactly X·Y·2^(−m) mod M, a value below M.
- R2: A write with `wr_en` high stores `wr_data` into word `wr_addr` of the operand picked by `wr_sel`: code 0 is X, 1 is Y, 2 is M. Word 0 holds the least significant W bits.
- R3: A `start` pulse seen while idle makes `busy` high from the next clock edge. `done` is high for exactly one cycle, and `busy` is low during that cycle.
- R4: A `start` pulse while `busy` is high has no effect. The run in progress keeps its length and its result.
- R5: Operand writes while `busy` is high are ignored. The run in progress uses the operands that were present at start.
- R6: While idle, `rd_data` gives word `rd_addr` of the result one clock after the address is applied. Word 0 is the least significant.
- R7: After reset, `busy` and `done` are low.
- R8: With e = m/W + 1, a run takes m·(e+2) cycles for the bit scan and e+1 cycles for the compare pass. It takes e+1 more cycles only when the subtraction is needed. `done` is raised on the clock edge that ends the last pass.
- R9: The partial sum starts from zero on every run, whatever an earlier run left in the sum RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand word write strobe |
| wr_sel | input | 2 | Operand select: 0 X, 1 Y, 2 M |
| wr_addr | input | log2(m/W) | Operand word index |
| wr_data | input | W | Operand word value |
| start | input | 1 | Begin a multiplication (single-cycle pulse) |
| rd_addr | input | log2(m/W) | Result word index |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | W | Registered result word |

## Verification
Random odd moduli with the top bit set exercise both the compare-only ending and the subtracting ending. A design with a wrong borrow chain would either return a value of M or more, or subtract when it must not. Edge values probe the carry path: M = 2^m − 1 with X = Y = M − 1, M = 3, X = 0, and X = Y = 1. An adder that drops its second carry bit, or a shift that takes the wrong bit, gives a wrong product on these inputs. Back-to-back runs catch a sum RAM that is not treated as zero at start. Start pulses and operand writes sent in the middle of a run would show up as a changed run length or a corrupted product if the block let them through.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_TOPCLR,
    ST_CMP,
    ST_SUB
  } mm_state_e;

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_M = 2'd2;
endpackage

// File: rtl/mm_word_ram.sv
module mm_word_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mm_word_add.sv
module mm_word_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] m_in,
  input  logic         x_bit,
  input  logic         q_bit,
  input  logic [1:0]   c_in,
  output logic [W-1:0] sum,
  output logic [1:0]   c_out
);
  logic [W+1:0] total;

  always_comb begin
    total = {2'b00, s_in} + {{W{1'b0}}, c_in};
    if (x_bit) total = total + {2'b00, y_in};
    if (q_bit) total = total + {2'b00, m_in};
  end

  assign sum   = total[W-1:0];
  assign c_out = total[W+1:W];
endmodule

// File: rtl/mm_word_sub.sv
module mm_word_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         b_in,
  output logic [W-1:0] diff,
  output logic         b_out
);
  logic [W:0] res;

  assign res   = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, b_in};
  assign diff  = res[W-1:0];
  assign b_out = res[W];
endmodule

// File: rtl/mont_mul_serial.sv
module mont_mul_serial
  import mm_pkg::*;
#(
  parameter int M_BITS = 2048,
  parameter int W      = 8,
  localparam int NWX   = M_BITS / W,
  localparam int AWH   = $clog2(NWX)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [AWH-1:0] wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           start,
  input  logic [AWH-1:0] rd_addr,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   rd_data
);
  localparam int E    = NWX + 1;
  localparam int NWS  = NWX + 2;
  localparam int AW_S = $clog2(NWS);
  localparam int IW   = $clog2(M_BITS);
  localparam int LW   = $clog2(W);
  localparam logic [AW_S-1:0] J_E   = AW_S'(E);
  localparam logic [AW_S-1:0] J_NWX = AW_S'(NWX);
  localparam logic [IW-1:0]   I_END = IW'(M_BITS - 1);

  mm_state_e       state_q;
  logic [IW-1:0]   i_q;
  logic [AW_S-1:0] j_q;
  logic [1:0]      c_q;
  logic            q_q;
  logic [W-1:0]    pend_q;
  logic            bor_q;
  logic            done_q;
  logic [W-1:0]    rd_q;

  logic            idle;
  logic            x_we, y_we, m_we;
  logic [W-1:0]    x_rdata, y_rdata, m_rdata, s_rdata;
  logic [W-1:0]    y_w, m_w, s_cur;
  logic            xb, q_new, q_use;
  logic [1:0]      c_in;
  logic [W-1:0]    sum;
  logic [1:0]      c_out;
  logic [W-1:0]    diff;
  logic            b_in, b_out;
  logic            s_we;
  logic [AW_S-1:0] s_waddr, s_raddr;
  logic [W-1:0]    s_wdata;

  assign idle = (state_q == ST_IDLE);
  assign x_we = wr_en && idle && (wr_sel == SEL_X);
  assign y_we = wr_en && idle && (wr_sel == SEL_Y);
  assign m_we = wr_en && idle && (wr_sel == SEL_M);

  mm_word_ram #(.DEPTH(NWX), .W(W)) u_xram (
    .clk(clk), .we(x_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(i_q[IW-1:LW]), .rdata(x_rdata));

  mm_word_ram #(.DEPTH(NWX), .W(W)) u_yram (
    .clk(clk), .we(y_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(j_q[AWH-1:0]), .rdata(y_rdata));

  mm_word_ram #(.DEPTH(NWX), .W(W)) u_mram (
    .clk(clk), .we(m_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(j_q[AWH-1:0]), .rdata(m_rdata));

  mm_word_ram #(.DEPTH(NWS), .W(W)) u_sram (
    .clk(clk), .we(s_we), .waddr(s_waddr), .wdata(s_wdata),
    .raddr(s_raddr), .rdata(s_rdata));

  assign s_raddr = idle ? AW_S'(rd_addr) : j_q;

  // Words above the operand length read as zero
  assign y_w   = (j_q < J_NWX) ? y_rdata : '0;
  assign m_w   = (j_q < J_NWX) ? m_rdata : '0;
  // First bit step treats the whole partial sum as zero
  assign s_cur = (i_q == '0) ? '0 : s_rdata;
  assign xb    = x_rdata[i_q[LW-1:0]];
  assign q_new = (xb & y_w[0]) ^ s_cur[0];
  assign q_use = (j_q == '0) ? q_new : q_q;
  assign c_in  = (j_q == '0) ? 2'b00 : c_q;
  assign b_in  = (j_q == '0) ? 1'b0 : bor_q;

  mm_word_add #(.W(W)) u_add (
    .s_in(s_cur), .y_in(y_w), .m_in(m_w), .x_bit(xb), .q_bit(q_use),
    .c_in(c_in), .sum(sum), .c_out(c_out));

  mm_word_sub #(.W(W)) u_sub (
    .a(s_rdata), .b(m_w), .b_in(b_in), .diff(diff), .b_out(b_out));

  always_comb begin
    s_we    = 1'b0;
    s_waddr = j_q;
    s_wdata = '0;
    case (state_q)
      ST_SCAN: begin
        if (j_q != '0) begin
          s_we    = 1'b1;
          s_waddr = j_q - 1'b1;
          s_wdata = {sum[0], pend_q[W-1:1]};
        end
      end
      ST_TOPCLR: begin
        s_we    = 1'b1;
        s_waddr = J_E;
      end
      ST_SUB: begin
        s_we    = 1'b1;
        s_wdata = diff;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      i_q     <= '0;
      j_q     <= '0;
      c_q     <= '0;
      q_q     <= 1'b0;
      pend_q  <= '0;
      bor_q   <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      rd_q   <= s_rdata;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SCAN;
            i_q     <= '0;
            j_q     <= '0;
          end
        end
        ST_SCAN: begin
          pend_q <= sum;
          c_q    <= c_out;
          if (j_q == '0) q_q <= q_new;
          if (j_q == J_E) state_q <= ST_TOPCLR;
          else            j_q     <= j_q + 1'b1;
        end
        ST_TOPCLR: begin
          j_q <= '0;
          c_q <= '0;
          if (i_q == I_END) begin
            state_q <= ST_CMP;
          end else begin
            i_q     <= i_q + 1'b1;
            state_q <= ST_SCAN;
          end
        end
        ST_CMP: begin
          bor_q <= b_out;
          if (j_q == J_E) begin
            j_q <= '0;
            if (!b_out) begin
              state_q <= ST_SUB;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_SUB: begin
          bor_q <= b_out;
          if (j_q == J_E) begin
            j_q     <= '0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = !idle;
  assign done    = done_q;
  assign rd_data = rd_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_q |-> (state_q == ST_IDLE)); // R3
  AST_CARRY_BOUND: assert property (@(posedge clk) disable iff (rst) (state_q == ST_SCAN) |-> (c_q != 2'd3)); // R1
  AST_TOPCLR_ORDER: assert property (@(posedge clk) disable iff (rst) (state_q == ST_TOPCLR) |-> ($past(state_q) == ST_SCAN && $past(j_q) == J_E)); // R8
  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (rst) (state_q != ST_IDLE) |-> (j_q <= J_E)); // R8
  AST_START_HELD: assert property (@(posedge clk) disable iff (rst) (state_q == ST_SCAN && j_q != '0) |=> (state_q != ST_IDLE)); // R4
endmodule

// File: tb/test_mont_mul_serial.sv
module test_mont_mul_serial;
  localparam int MB = 64;
  localparam int WB = 8;
  localparam int NW = MB / WB;
  localparam int E  = NW + 1;
  localparam int T_NOSUB = MB * (E + 2) + E + 2;
  localparam int T_SUB   = T_NOSUB + E + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [2:0]    wr_addr = '0;
  logic [WB-1:0] wr_data = '0;
  logic          start = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic          busy, done;
  logic [WB-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int start_cyc = 0;
  int pushed = 0;
  int popped = 0;
  logic [63:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mont_mul_serial #(.M_BITS(MB), .W(WB)) i_mont_mul_serial (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .rd_addr(rd_addr), .busy(busy),
    .done(done), .rd_data(rd_data));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mont_ref(input logic [63:0] x, input logic [63:0] y, input logic [63:0] m);
    logic [129:0] r;
    r = ({66'd0, x} * {66'd0, y}) % {66'd0, m};
    for (int k = 0; k < MB; k++) r = r[0] ? ((r + {66'd0, m}) >> 1) : (r >> 1);
    return r[63:0];
  endfunction

  task automatic load(input logic [1:0] sel, input logic [63:0] val);
    for (int k = 0; k < NW; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = 3'(k); wr_data = val[k*WB +: WB];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: loads operands, pushes the expected product, starts the run
  task automatic run(input logic [63:0] x, input logic [63:0] y, input logic [63:0] m, input bit disturb);
    load(2'd0, x);  // R2
    load(2'd1, y);
    load(2'd2, m);
    exp_q.push_back(mont_ref(x, y, m));
    pushed++;
    @(negedge clk);
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R3 busy after start", 64'(busy), 64'd1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      start = 1'b1;  // R4 ignored while busy
      wr_en = 1'b1; wr_sel = 2'd1; wr_addr = 3'd0; wr_data = ~y[7:0];  // R5
      @(negedge clk);
      start = 1'b0;
      wr_sel = 2'd2; wr_addr = 3'd3; wr_data = ~m[31:24];
      @(negedge clk);
      wr_sel = 2'd0; wr_addr = 3'd7; wr_data = ~x[63:56];
      @(negedge clk);
      wr_en = 1'b0;
    end
    wait (popped == pushed);
    @(negedge clk);
  endtask

  // Monitor: on done, pops the expected value and reads the result back
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        logic [63:0] exp, got;
        int delta;
        exp = exp_q.pop_front();
        delta = cyc - start_cyc;
        check(delta == T_NOSUB || delta == T_SUB, "R8 R4 run length", 64'(delta), 64'(T_NOSUB));
        check(busy == 1'b0, "R3 busy low with done", 64'(busy), 64'd0);
        got = '0;
        for (int k = 0; k < NW; k++) begin
          rd_addr = 3'(k);
          @(negedge clk);
          if (k == 0) check(done == 1'b0, "R3 done one cycle", 64'(done), 64'd0);
          got[k*WB +: WB] = rd_data;
        end
        check(got == exp, "R1 R6 R5 R9 product", got, exp);
        popped++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] m, x, y;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R7 busy after reset", 64'(busy), 64'd0);
    check(done == 1'b0, "R7 done after reset", 64'(done), 64'd0);

    run(64'd0, 64'd5, 64'hF00D_0000_1234_5677, 1'b0);             // R1 zero operand
    run(64'd1, 64'd1, 64'hC3A5_9E11_7F02_B44D, 1'b0);             // R1 pure 2^-m
    run(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE,
        64'hFFFF_FFFF_FFFF_FFFF, 1'b0);                           // R1 maximal carries
    run(64'd2, 64'd2, 64'd3, 1'b0);                               // R1 tiny modulus
    run(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
        64'h8000_0000_0000_0001, 1'b0);                           // R1 R9
    for (int n = 0; n < 10; n++) begin
      m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
      x = {$urandom, $urandom} % m;
      y = {$urandom, $urandom} % m;
      run(x, y, m, (n % 3) == 0);                                 // R1 R4 R5
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule